// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table kept in memory. The virtual address is 14 bits: an 8-bit virtual page number above a 6-bit byte offset within a 64-byte page. The top four bits of the page number select an entry in the page directory. The low four bits select one of sixteen 4-byte entries in a page-table page. When a miss is offered, the walker reads the directory entry. If that entry is present, the walker reads the table entry it points to. It then checks the requested access against the entry's permission bits.

A successful walk ends with a fill toward the translation buffer that carries the page number, the frame number and the permission bits. A walk that fails ends with a fault pulse and a 2-bit cause code: the directory entry is absent, the table entry is absent, or the access is not permitted. Memory is reached through a single-outstanding read port for 32-bit words. A request is held until it is accepted, and its response comes back on a separate valid strobe. The directory base is sampled when the miss is accepted. Only one walk is in flight at any time.

Top module: `page_walker`

## Requirements
- R1: The directory index is VPN bits 7..4. The first read of a walk goes to the directory base plus four times that index.
- R2: The table index is VPN bits 3..0. The second read goes to the directory entry's frame number shifted left by 6, plus four times the table index.
- R3: Directory and table entries share one format: bit 0 present, bit 1 read allowed, bit 2 write allowed, bit 3 execute allowed. The frame number occupies the topmost PADDR_W-6 bits of the 32-bit word.
- R4: A directory entry with bit 0 clear ends the walk with fault and cause 1, after exactly one memory read. No second read is issued.
- R5: A table entry with bit 0 clear ends the walk with fault and cause 2.
- R6: Access codes are 0 = read, 1 = write and 2 = execute. Each needs the matching table-entry bit set, or the walk ends with fault and cause 3. Code 3 always ends with cause 3.
- R7: A permitted walk costs exactly two reads. It ends with fillValid high, fillVpn equal to the miss VPN, fillPfn equal to the table entry's frame number, fillPerm equal to table-entry bits 3..1, and faultCause 0.
- R8: done is high for one cycle per walk. fillValid and fault are only ever high together with done, and never both at once. faultCause is nonzero exactly when fault is high.
- R9: missReady is high only while idle. A miss offered while a walk is in flight is ignored and does not change that walk's result.
- R10: A memory request keeps memReqValid high and memReqAddr stable until memReqReady. No new request is made while a response is outstanding.
- R11: After reset, missReady is 1 and memReqValid, done, fillValid and fault are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Translation miss offered |
| missReady | output | 1 | Walker idle, miss accepted this cycle |
| missVpn | input | VPN_W | Virtual page number of the miss |
| missAcc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| dirBase | input | PADDR_W | Physical byte address of the page directory |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | PADDR_W | Byte address of the 32-bit word to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data word |
| done | output | 1 | Walk finished (one-cycle pulse) |
| fillValid | output | 1 | Translation fill for the TLB |
| fillVpn | output | VPN_W | Filled virtual page number |
| fillPfn | output | PADDR_W-OFF_W | Filled physical frame number |
| fillPerm | output | 3 | Filled permissions {execute, write, read} |
| fault | output | 1 | Walk ended in a fault |
| faultCause | output | 2 | 1 directory absent, 2 table absent, 3 protection |

## Verification
The bench builds the walker with PADDR_W = 12 and the default split of 8-bit VPN and 6-bit offset. Frame numbers are therefore 6 bits wide and sit in data bits 31..26. With this setting a directory, several table pages and their data frames fit into a 1024-word bench memory, so every directory slot, present or absent, can be reached and the address formulas can be checked at both ends of the index range. A stall knob on the memory ready line holds requests for several cycles, which is what allows a miss to be offered while a walk is already in flight.

// File: rtl/walker_pkg.sv
package walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_PDE,
    ST_WAIT_PDE,
    ST_READ_PTE,
    ST_WAIT_PTE,
    ST_DONE
  } walkState_e;

  typedef enum logic [1:0] {
    FC_NONE        = 2'd0,
    FC_DIR_ABSENT  = 2'd1,
    FC_TBL_ABSENT  = 2'd2,
    FC_PROT        = 2'd3
  } faultCode_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_READ    = 1;
  localparam int BIT_WRITE   = 2;
  localparam int BIT_EXEC    = 3;

  typedef struct packed {
    logic loadMiss;
    logic selTable;
    logic capDir;
    logic capTbl;
    logic showResult;
  } ctlStrobes_t;

  typedef struct packed {
    logic rspPresent;
  } dpStatus_t;

endpackage

// File: rtl/walker_ctrl.sv
module walker_ctrl
  import walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  dpStatus_t   status,
  output logic        missReady,
  output logic        memReqValid,
  output logic        done,
  output ctlStrobes_t strobes
);

  walkState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:     if (missValid) stateD = ST_READ_PDE;
      ST_READ_PDE: if (memReqReady) stateD = ST_WAIT_PDE;
      ST_WAIT_PDE: if (memRspValid) stateD = status.rspPresent ? ST_READ_PTE : ST_DONE;
      ST_READ_PTE: if (memReqReady) stateD = ST_WAIT_PTE;
      ST_WAIT_PTE: if (memRspValid) stateD = ST_DONE;
      ST_DONE:     stateD = ST_IDLE;
      default:     stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign missReady          = (stateQ == ST_IDLE);
  assign memReqValid        = (stateQ == ST_READ_PDE) || (stateQ == ST_READ_PTE);
  assign done               = (stateQ == ST_DONE);
  assign strobes.loadMiss   = (stateQ == ST_IDLE) && missValid;
  assign strobes.selTable   = (stateQ == ST_READ_PTE);
  assign strobes.capDir     = (stateQ == ST_WAIT_PDE) && memRspValid;
  assign strobes.capTbl     = (stateQ == ST_WAIT_PTE) && memRspValid;
  assign strobes.showResult = (stateQ == ST_DONE);

endmodule

// File: rtl/walker_datapath.sv
module walker_datapath
  import walker_pkg::*;
#(
  parameter int VPN_W   = 8,
  parameter int DIR_W   = 4,
  parameter int OFF_W   = 6,
  parameter int PADDR_W = 16,
  parameter int WORD_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              strobes,
  input  logic [VPN_W-1:0]         missVpn,
  input  logic [1:0]               missAcc,
  input  logic [PADDR_W-1:0]       dirBase,
  input  logic [WORD_W-1:0]        memRspData,
  output dpStatus_t                status,
  output logic [PADDR_W-1:0]       memReqAddr,
  output logic                     fillValid,
  output logic [VPN_W-1:0]         fillVpn,
  output logic [PADDR_W-OFF_W-1:0] fillPfn,
  output logic [2:0]               fillPerm,
  output logic                     fault,
  output logic [1:0]               faultCause
);

  localparam int TBL_W = VPN_W - DIR_W;
  localparam int PFN_W = PADDR_W - OFF_W;
  localparam int IDX_SHIFT = 2;

  logic [VPN_W-1:0]   vpnQ;
  logic [1:0]         accQ;
  logic [PADDR_W-1:0] baseQ;
  logic [PFN_W-1:0]   tblPfnQ;
  logic [PFN_W-1:0]   outPfnQ;
  logic [2:0]         outPermQ;
  faultCode_e         causeQ;

  logic [DIR_W-1:0]   dirIdx;
  logic [TBL_W-1:0]   tblIdx;
  logic [PADDR_W-1:0] dirAddr;
  logic [PADDR_W-1:0] tblAddr;
  logic [PFN_W-1:0]   rspPfn;
  logic               rspPresent;
  logic               permOk;

  assign dirIdx = vpnQ[VPN_W-1 -: DIR_W];
  assign tblIdx = vpnQ[TBL_W-1:0];

  assign dirAddr = baseQ + PADDR_W'({dirIdx, {IDX_SHIFT{1'b0}}});
  assign tblAddr = {tblPfnQ, {OFF_W{1'b0}}} + PADDR_W'({tblIdx, {IDX_SHIFT{1'b0}}});
  assign memReqAddr = strobes.selTable ? tblAddr : dirAddr;

  assign rspPfn     = memRspData[WORD_W-1 -: PFN_W];
  assign rspPresent = memRspData[BIT_PRESENT];
  assign status.rspPresent = rspPresent;

  always_comb begin
    unique case (accQ)
      ACC_READ:  permOk = memRspData[BIT_READ];
      ACC_WRITE: permOk = memRspData[BIT_WRITE];
      ACC_EXEC:  permOk = memRspData[BIT_EXEC];
      default:   permOk = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ     <= '0;
      accQ     <= '0;
      baseQ    <= '0;
      tblPfnQ  <= '0;
      outPfnQ  <= '0;
      outPermQ <= '0;
      causeQ   <= FC_NONE;
    end else begin
      if (strobes.loadMiss) begin
        vpnQ   <= missVpn;
        accQ   <= missAcc;
        baseQ  <= dirBase;
        causeQ <= FC_NONE;
      end
      if (strobes.capDir) begin
        tblPfnQ <= rspPfn;
        if (!rspPresent) causeQ <= FC_DIR_ABSENT;
      end
      if (strobes.capTbl) begin
        outPfnQ  <= rspPfn;
        outPermQ <= memRspData[BIT_EXEC:BIT_READ];
        if (!rspPresent)  causeQ <= FC_TBL_ABSENT;
        else if (!permOk) causeQ <= FC_PROT;
        else              causeQ <= FC_NONE;
      end
    end
  end

  assign fillValid  = strobes.showResult && (causeQ == FC_NONE);
  assign fault      = strobes.showResult && (causeQ != FC_NONE);
  assign faultCause = fault ? causeQ : FC_NONE;
  assign fillVpn    = vpnQ;
  assign fillPfn    = outPfnQ;
  assign fillPerm   = outPermQ;

endmodule

// File: rtl/page_walker.sv
module page_walker
  import walker_pkg::*;
#(
  parameter int VPN_W   = 8,
  parameter int DIR_W   = 4,
  parameter int OFF_W   = 6,
  parameter int PADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     missValid,
  output logic                     missReady,
  input  logic [VPN_W-1:0]         missVpn,
  input  logic [1:0]               missAcc,
  input  logic [PADDR_W-1:0]       dirBase,
  output logic                     memReqValid,
  input  logic                     memReqReady,
  output logic [PADDR_W-1:0]       memReqAddr,
  input  logic                     memRspValid,
  input  logic [31:0]              memRspData,
  output logic                     done,
  output logic                     fillValid,
  output logic [VPN_W-1:0]         fillVpn,
  output logic [PADDR_W-OFF_W-1:0] fillPfn,
  output logic [2:0]               fillPerm,
  output logic                     fault,
  output logic [1:0]               faultCause
);

  ctlStrobes_t strobes;
  dpStatus_t   status;

  walker_ctrl ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .status      (status),
    .missReady   (missReady),
    .memReqValid (memReqValid),
    .done        (done),
    .strobes     (strobes)
  );

  walker_datapath #(
    .VPN_W   (VPN_W),
    .DIR_W   (DIR_W),
    .OFF_W   (OFF_W),
    .PADDR_W (PADDR_W),
    .WORD_W  (32)
  ) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .missVpn    (missVpn),
    .missAcc    (missAcc),
    .dirBase    (dirBase),
    .memRspData (memRspData),
    .status     (status),
    .memReqAddr (memReqAddr),
    .fillValid  (fillValid),
    .fillVpn    (fillVpn),
    .fillPfn    (fillPfn),
    .fillPerm   (fillPerm),
    .fault      (fault),
    .faultCause (faultCause)
  );

endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk #(
  parameter int PADDR_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               missValid,
  input logic               missReady,
  input logic               memReqValid,
  input logic               memReqReady,
  input logic [PADDR_W-1:0] memReqAddr,
  input logic               memRspValid,
  input logic               done,
  input logic               fillValid,
  input logic               fault,
  input logic [1:0]         faultCause
);

  logic [1:0] readCnt;
  logic       pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readCnt <= '0;
      pending <= 1'b0;
    end else begin
      if (missValid && missReady) readCnt <= '0;
      else if (memReqValid && memReqReady && readCnt != 2'd3) readCnt <= readCnt + 2'd1;
      if (memReqValid && memReqReady) pending <= 1'b1;
      else if (memRspValid)           pending <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !memReqValid); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid || fault) |-> done && (fillValid != fault)); // R8
  AST_CAUSE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> faultCause != 2'd0); // R8
  AST_DIR_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    fault && faultCause == 2'd1 |-> readCnt == 2'd1); // R4
  AST_FILL_TWO_READS: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> readCnt == 2'd2); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    missReady |-> !memReqValid && !done); // R9

endmodule

bind page_walker page_walker_chk #(.PADDR_W(PADDR_W)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .missValid   (missValid),
  .missReady   (missReady),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid),
  .done        (done),
  .fillValid   (fillValid),
  .fault       (fault),
  .faultCause  (faultCause)
);

// File: tb/page_walker_test.sv
module page_walker_test;

  localparam int VPN_W   = 8;
  localparam int OFF_W   = 6;
  localparam int PADDR_W = 12;
  localparam int PFN_W   = PADDR_W - OFF_W;
  localparam logic [PADDR_W-1:0] DIR_BASE = 12'h100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rstN = 1'b0;
  logic               missValid = 1'b0;
  logic               missReady;
  logic [VPN_W-1:0]   missVpn = '0;
  logic [1:0]         missAcc = '0;
  logic               memReqValid;
  logic               memReqReady;
  logic [PADDR_W-1:0] memReqAddr;
  logic               memRspValid;
  logic [31:0]        memRspData;
  logic               done, fillValid, fault;
  logic [VPN_W-1:0]   fillVpn;
  logic [PFN_W-1:0]   fillPfn;
  logic [2:0]         fillPerm;
  logic [1:0]         faultCause;

  page_walker #(.VPN_W(VPN_W), .DIR_W(4), .OFF_W(OFF_W), .PADDR_W(PADDR_W)) uut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missReady(missReady),
    .missVpn(missVpn), .missAcc(missAcc), .dirBase(DIR_BASE),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .done(done),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPfn(fillPfn), .fillPerm(fillPerm),
    .fault(fault), .faultCause(faultCause)
  );

  // memory model
  logic [31:0]        memWords [1024];
  logic [PADDR_W-1:0] addrLog [64];
  int                 readCount;
  int                 stallCnt;
  int                 stallLoad = 0;
  logic               rspPend;
  logic [31:0]        rspData;

  assign memReqReady = (stallCnt == 0);
  assign memRspValid = rspPend;
  assign memRspData  = rspData;

  always @(posedge clk) begin
    if (!rstN) begin
      readCount <= 0;
      stallCnt  <= 0;
      rspPend   <= 1'b0;
      rspData   <= '0;
    end else begin
      rspPend <= 1'b0;
      if (memReqValid) begin
        if (stallCnt != 0) stallCnt <= stallCnt - 1;
        else begin
          rspPend   <= 1'b1;
          rspData   <= memWords[memReqAddr[PADDR_W-1:2]];
          addrLog[readCount[5:0]] <= memReqAddr;
          readCount <= readCount + 1;
          stallCnt  <= stallLoad;
        end
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // entry: frame in top PFN_W bits, {x,w,r} in bits 3..1, present in bit 0
  function automatic logic [31:0] mkEntry(input int pfn, input logic [2:0] perm, input bit present);
    return (32'(pfn) << (32 - PFN_W)) | (32'(perm) << 1) | 32'(present);
  endfunction

  function automatic int wordIdx(input int byteAddr);
    return byteAddr >> 2;
  endfunction

  // {vpn, acc, cause, pfn}
  localparam int NVEC = 15;
  localparam logic [17:0] VEC [NVEC] = '{
    {8'h00, 2'd0, 2'd0, 6'd20},
    {8'h00, 2'd2, 2'd0, 6'd20},
    {8'h00, 2'd1, 2'd3, 6'd0},
    {8'h01, 2'd1, 2'd0, 6'd21},
    {8'h02, 2'd0, 2'd2, 6'd0},
    {8'h03, 2'd1, 2'd3, 6'd0},
    {8'h03, 2'd0, 2'd0, 6'd23},
    {8'h04, 2'd0, 2'd3, 6'd0},
    {8'hFF, 2'd2, 2'd0, 6'd63},
    {8'hFE, 2'd2, 2'd0, 6'd1},
    {8'hFE, 2'd0, 2'd3, 6'd0},
    {8'h30, 2'd0, 2'd1, 6'd0},
    {8'h57, 2'd1, 2'd0, 6'd33},
    {8'h57, 2'd3, 2'd3, 6'd0},
    {8'h80, 2'd0, 2'd1, 6'd0}
  };

  function automatic int dirPfnOf(input int dir);
    case (dir)
      0:  return 8;
      5:  return 10;
      15: return 9;
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] permOf(input int vpn);
    case (vpn)
      8'h00: return 3'b101;
      8'h01: return 3'b011;
      8'h03: return 3'b001;
      8'h04: return 3'b000;
      8'hFF: return 3'b111;
      8'hFE: return 3'b100;
      8'h57: return 3'b010;
      default: return 3'b000;
    endcase
  endfunction

  int rDone, rFill, rFault, rCause, rPfn, rPerm, rVpn, rReads, rBase;

  task automatic walk(input int vpn, input int acc);
    int waitCyc;
    @(negedge clk);
    rBase     = readCount;
    missVpn   = vpn[7:0];
    missAcc   = acc[1:0];
    missValid = 1'b1;
    @(negedge clk);
    missValid = 1'b0;
    waitCyc = 0;
    while (!done && waitCyc < 200) begin
      @(negedge clk);
      waitCyc++;
    end
    rDone = done; rFill = fillValid; rFault = fault; rCause = faultCause;
    rPfn = fillPfn; rPerm = fillPerm; rVpn = fillVpn; rReads = readCount - rBase;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) memWords[i] = '0;
    memWords[wordIdx(DIR_BASE + 0*4)]  = mkEntry(8, 3'b000, 1);
    memWords[wordIdx(DIR_BASE + 5*4)]  = mkEntry(10, 3'b000, 1);
    memWords[wordIdx(DIR_BASE + 15*4)] = mkEntry(9, 3'b000, 1);
    memWords[wordIdx(DIR_BASE + 3*4)]  = mkEntry(12, 3'b111, 0);
    memWords[wordIdx((8 << 6) + 0*4)]  = mkEntry(20, 3'b101, 1);
    memWords[wordIdx((8 << 6) + 1*4)]  = mkEntry(21, 3'b011, 1);
    memWords[wordIdx((8 << 6) + 2*4)]  = mkEntry(22, 3'b111, 0);
    memWords[wordIdx((8 << 6) + 3*4)]  = mkEntry(23, 3'b001, 1);
    memWords[wordIdx((8 << 6) + 4*4)]  = mkEntry(24, 3'b000, 1);
    memWords[wordIdx((9 << 6) + 15*4)] = mkEntry(63, 3'b111, 1);
    memWords[wordIdx((9 << 6) + 14*4)] = mkEntry(1, 3'b100, 1);
    memWords[wordIdx((10 << 6) + 7*4)] = mkEntry(33, 3'b010, 1);
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(missReady == 1'b1, "R11 missReady", missReady, 1);
    check(memReqValid == 1'b0 && done == 1'b0, "R11 req/done", {memReqValid, done}, 0);
    check(fillValid == 1'b0 && fault == 1'b0, "R11 fill/fault", {fillValid, fault}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(missReady == 1'b1 && memReqValid == 1'b0, "R11 after release", {missReady, memReqValid}, 2);

    // vector table: R1 R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      int vpn, acc, expCause, expPfn, dir, tbl, dpfn;
      vpn = VEC[v][17:10]; acc = VEC[v][9:8]; expCause = VEC[v][7:6]; expPfn = VEC[v][5:0];
      dir = vpn >> 4; tbl = vpn & 15; dpfn = dirPfnOf(dir);
      stallLoad = v % 3;
      walk(vpn, acc);
      check(rDone == 1, "R8 done seen", rDone, 1);
      check(addrLog[rBase[5:0]] == 12'(DIR_BASE + dir*4), "R1 directory address",
            addrLog[rBase[5:0]], DIR_BASE + dir*4);
      if (expCause == 1) begin
        check(rReads == 1, "R4 single read", rReads, 1);
        check(rFault == 1 && rCause == 1, "R4 cause", rCause, 1);
      end else begin
        check(rReads == 2, "R7 two reads", rReads, 2);
        check(addrLog[6'(rBase + 1)] == 12'((dpfn << 6) + tbl*4), "R2 table address",
              addrLog[6'(rBase + 1)], (dpfn << 6) + tbl*4);
        if (expCause == 0) begin
          check(rFill == 1 && rFault == 0 && rCause == 0, "R7 fill", {rFill, rFault}, 2);
          check(rPfn == expPfn, "R3 frame field", rPfn, expPfn);
          check(rVpn == vpn, "R7 fill vpn", rVpn, vpn);
          check(rPerm == permOf(vpn), "R3 permission bits", rPerm, permOf(vpn));
        end else if (expCause == 2) begin
          check(rFault == 1 && rFill == 0 && rCause == 2, "R5 cause", rCause, 2);
        end else begin
          check(rFault == 1 && rFill == 0 && rCause == 3, "R6 cause", rCause, 3);
        end
      end
      @(negedge clk);
      check(done == 0 && missReady == 1, "R8 pulse ends", {done, missReady}, 1);
    end

    // R9: miss offered while busy is ignored
    stallLoad = 4;
    @(negedge clk);
    rBase = readCount;
    missVpn = 8'hFF; missAcc = 2'd2; missValid = 1'b1;
    @(negedge clk);
    missVpn = 8'h30; missAcc = 2'd0;
    repeat (3) begin
      check(missReady == 0, "R9 busy not ready", missReady, 0);
      @(negedge clk);
    end
    missValid = 1'b0;
    while (!done) @(negedge clk);
    check(fillValid == 1 && fillPfn == 6'd63 && fillVpn == 8'hFF, "R9 walk unaffected",
          fillPfn, 63);
    check(readCount - rBase == 2, "R9 no extra reads", readCount - rBase, 2);

    // R10: request held stable during a stall
    stallLoad = 0;
    @(negedge clk);
    @(negedge clk);
    stallLoad = 5;
    walk(8'h01, 1);
    stallLoad = 5;
    @(negedge clk);
    missVpn = 8'h57; missAcc = 2'd1; missValid = 1'b1;
    @(negedge clk);
    missValid = 1'b0;
    check(memReqValid == 1 && memReqAddr == 12'(DIR_BASE + 5*4), "R10 request raised",
          memReqAddr, DIR_BASE + 20);
    repeat (3) begin
      @(negedge clk);
      check(memReqValid == 1 && memReqAddr == 12'(DIR_BASE + 5*4), "R10 request held",
            memReqAddr, DIR_BASE + 20);
    end
    while (!done) @(negedge clk);
    check(fillValid == 1 && fillPfn == 6'd33, "R10 stalled walk result", fillPfn, 33);
    stallLoad = 0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule